// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block turns one CPU-side access request into a complete external memory cycle. A request carries an address, a read/write flag, a word/byte size flag, an instruction-fetch flag and write data. Once accepted, the controller runs a fixed sequence: one address cycle with the latch strobe, one data cycle with the read or write strobe active, a programmed number of wait states, more wait states while the ready input is low, and one hold cycle with every strobe released. A one-cycle done pulse then returns the read data.

The shared 16-line address/data bus runs in one of four modes, chosen at run time: 16-bit or 8-bit width, each multiplexed or demultiplexed. A separate full address output holds the address for the whole cycle. The high-byte pin can act in two ways. It can be an active-low byte enable, decoded together with address bit 0. It can also be a high-byte write strobe paired with a low-byte write strobe. Pad drive is modelled as one output-enable per byte lane.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, busy, done, ale, inst and both lane enables are 0, and rdN, wrN and bheN are 1.
- R2: A request is accepted only while busy is 0. busy is 1 from the cycle after acceptance up to the done cycle. Requests, mode bits and the wait count presented while busy have no effect on the running cycle, because the mode and wait settings are taken at acceptance.
- R3: ale is 1 in exactly the first cycle after acceptance. done is 1 for exactly one cycle, right after the hold cycle, and busy is 0 in that cycle. A new request may be accepted at the end of that same cycle.
- R4: The strobe is active for 1+max(W,N) cycles. W is the programmed wait count (0–3) and N is the number of leading strobe cycles in which ready is sampled low. After the strobe comes one hold cycle with all strobes released.
- R5: In 16-bit multiplexed mode, both lanes carry address bits 15:0 in the address cycle. For a write they then carry data through the strobe and hold cycles. For a read, both lane enables are 0 after the address cycle.
- R6: In 8-bit multiplexed mode, the upper lane drives address bits 15:8 for the whole cycle. The lower lane carries address bits 7:0 and then write data (low byte), or is released for a read. On the 8-bit bus every access moves a single byte, and the size flag is ignored.
- R7: In 16-bit demultiplexed mode, both lanes carry write data for the whole cycle and are released for reads. In 8-bit demultiplexed mode, the upper lane drives write-data bits 15:8 for the whole cycle. The lower lane carries write-data bits 7:0 on writes.
- R8: With the byte-enable setting (cfgBheMode=1), wrN is low during the strobe of every write. On the 16-bit bus, bheN is low for the whole cycle for a word or for a byte with address bit 0 = 1, so that (bheN,a0)=(0,0) means both bytes, (0,1) the high byte and (1,0) the low byte. On the 8-bit bus bheN stays 1.
- R9: With the write-strobe setting (cfgBheMode=0), on the 16-bit bus wrN is the low-byte write strobe (word, or byte with a0=0) and bheN is the high-byte write strobe (word, or byte with a0=1). Both are active only during the strobe. On the 8-bit bus wrN strobes every write.
- R10: rdN is low only during the strobe of reads. For reads, rdata at done equals the lanes sampled in the last strobe cycle: all 16 bits for a word on the 16-bit bus, otherwise the selected byte (high lane when a0=1 on the 16-bit bus) zero-extended.
- R11: inst is 1 for the whole cycle (address through hold) of a read whose fetch flag is set, and 0 otherwise.
- R12: Outside a cycle (busy=0) both lane enables are 0, so the lines fall back to their port function.
- R13: addrOut holds the full request address from the address cycle through the hold cycle and is 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Request address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = word, 0 = byte |
| reqFetch | input | 1 | Instruction-fetch flag |
| reqWdata | input | 16 | Write data (byte writes use bits 7:0) |
| cfgWide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfgMux | input | 1 | 1 = multiplexed, 0 = demultiplexed |
| cfgBheMode | input | 1 | 1 = byte enable, 0 = high-byte write strobe |
| cfgWaitMin | input | WAIT_W | Minimum wait states (0–3) |
| busReady | input | 1 | Active-high ready |
| adIn | input | 16 | Shared lines as read from the pads |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data |
| addrOut | output | ADDR_W | Address output |
| adOut | output | 16 | Shared lines drive value |
| adOe | output | 2 | Lane enables (bit 0 lines 7:0, bit 1 lines 15:8) |
| ale | output | 1 | Address latch strobe, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe or low-byte write strobe, active low |
| bheN | output | 1 | High-byte enable or high-byte write strobe, active low |
| inst | output | 1 | Instruction-fetch indicator |

## Verification
The done pulse of one cycle and the acceptance of the next request fall in the same clock. The bench provokes this on every transaction by presenting the next request in the very cycle it expects done, so the sweep runs back-to-back. It judges the overlap by requiring done=1 with busy=0 and idle lanes in that cycle, followed by an address cycle with ale and the new address in the next one. A second overlap is tested separately: requests and mode changes arriving mid-cycle. Those transactions are compared against the settings captured at acceptance.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_DATA, S_WAIT, S_HOLD
  } busState_t;

  typedef struct packed {
    logic load;      // latch request and mode
    logic phAddr;    // address cycle
    logic phStrobe;  // data or wait cycle
    logic phHold;    // hold cycle
    logic capture;   // last strobe cycle: sample read data
  } busCtl_t;
endpackage

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [WAIT_W-1:0] cfgWaitMin,
  input  logic              busReady,
  output busCtl_t           ctl,
  output logic              busy,
  output logic              done
);
  busState_t         state, stateNext;
  logic [WAIT_W-1:0] waitMinReg;
  logic [WAIT_W-1:0] waitCnt;
  logic              toHold;

  always_comb begin
    stateNext = state;
    toHold    = 1'b0;
    unique case (state)
      S_IDLE: if (reqValid) stateNext = S_ADDR;
      S_ADDR: stateNext = S_DATA;
      S_DATA: begin
        if (waitMinReg == '0 && busReady) begin
          stateNext = S_HOLD;
          toHold    = 1'b1;
        end else begin
          stateNext = S_WAIT;
        end
      end
      S_WAIT: begin
        if (waitCnt >= waitMinReg && busReady) begin
          stateNext = S_HOLD;
          toHold    = 1'b1;
        end
      end
      S_HOLD: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      waitMinReg <= '0;
      waitCnt    <= '0;
      done       <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == S_HOLD);
      if (state == S_IDLE && reqValid) waitMinReg <= cfgWaitMin;
      if (state == S_DATA) begin
        waitCnt <= WAIT_W'(1);
      end else if (state == S_WAIT && waitCnt < waitMinReg) begin
        waitCnt <= waitCnt + WAIT_W'(1);
      end
    end
  end

  always_comb begin
    ctl.load     = (state == S_IDLE) && reqValid;
    ctl.phAddr   = (state == S_ADDR);
    ctl.phStrobe = (state == S_DATA) || (state == S_WAIT);
    ctl.phHold   = (state == S_HOLD);
    ctl.capture  = toHold;
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/ebc_dpath.sv
module ebc_dpath
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic              reqFetch,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cfgWide,
  input  logic              cfgMux,
  input  logic              cfgBheMode,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] adOut,
  output logic [LANES-1:0]  adOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              bheN,
  output logic              inst
);
  logic [ADDR_W-1:0] aReg;
  logic [DATA_W-1:0] wdReg;
  logic wrReg, wordReg, fetchReg, wideReg, muxReg, bheModeReg;
  logic busyPh, dataPh, hiSel, loSel;
  logic [DATA_W-1:0] wd16;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg       <= '0;
      wdReg      <= '0;
      wrReg      <= 1'b0;
      wordReg    <= 1'b0;
      fetchReg   <= 1'b0;
      wideReg    <= 1'b0;
      muxReg     <= 1'b0;
      bheModeReg <= 1'b1;
    end else if (ctl.load) begin
      aReg       <= reqAddr;
      wdReg      <= reqWdata;
      wrReg      <= reqWrite;
      wordReg    <= reqWord;
      fetchReg   <= reqFetch;
      wideReg    <= cfgWide;
      muxReg     <= cfgMux;
      bheModeReg <= cfgBheMode;
    end
  end

  assign busyPh = ctl.phAddr | ctl.phStrobe | ctl.phHold;
  assign dataPh = ctl.phStrobe | ctl.phHold;
  assign hiSel  = wideReg && (wordReg || aReg[0]);
  assign loSel  = !wideReg || wordReg || !aReg[0];
  assign wd16   = wordReg ? wdReg : {wdReg[LANE_W-1:0], wdReg[LANE_W-1:0]};

  // Strobes
  always_comb begin
    ale  = ctl.phAddr;
    rdN  = !(ctl.phStrobe && !wrReg);
    inst = busyPh && fetchReg && !wrReg;
    if (bheModeReg) begin
      wrN  = !(ctl.phStrobe && wrReg);
      bheN = !(busyPh && hiSel);
    end else begin
      wrN  = !(ctl.phStrobe && wrReg && loSel);
      bheN = !(ctl.phStrobe && wrReg && hiSel);
    end
  end

  assign addrOut = busyPh ? aReg : '0;

  // Per-lane drive
  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam bit IS_HI = (g == LANES - 1);
    logic [LANE_W-1:0] laneOut, addrSlice, dataSlice;
    logic              laneOe;

    assign addrSlice = aReg[g*LANE_W +: LANE_W];
    assign dataSlice = wideReg ? wd16[g*LANE_W +: LANE_W] : wdReg[g*LANE_W +: LANE_W];

    always_comb begin
      laneOut = '0;
      laneOe  = 1'b0;
      if (muxReg) begin
        if (!wideReg && IS_HI) begin
          laneOe  = busyPh;
          laneOut = busyPh ? addrSlice : '0;
        end else if (ctl.phAddr) begin
          laneOe  = 1'b1;
          laneOut = addrSlice;
        end else if (dataPh && wrReg) begin
          laneOe  = 1'b1;
          laneOut = dataSlice;
        end
      end else begin
        if (!wideReg && IS_HI) begin
          laneOe  = busyPh;
          laneOut = busyPh ? dataSlice : '0;
        end else if (busyPh && wrReg) begin
          laneOe  = 1'b1;
          laneOut = dataSlice;
        end
      end
    end

    assign adOut[g*LANE_W +: LANE_W] = laneOut;
    assign adOe[g] = laneOe;
  end

  // Read data capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (ctl.capture && !wrReg) begin
      if (wideReg && wordReg)
        rdata <= adIn;
      else if (wideReg && aReg[0])
        rdata <= {{LANE_W{1'b0}}, adIn[DATA_W-1:LANE_W]};
      else
        rdata <= {{LANE_W{1'b0}}, adIn[LANE_W-1:0]};
    end
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic              reqFetch,
  input  logic [15:0]       reqWdata,
  input  logic              cfgWide,
  input  logic              cfgMux,
  input  logic              cfgBheMode,
  input  logic [WAIT_W-1:0] cfgWaitMin,
  input  logic              busReady,
  input  logic [15:0]       adIn,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rdata,
  output logic [ADDR_W-1:0] addrOut,
  output logic [15:0]       adOut,
  output logic [1:0]        adOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              bheN,
  output logic              inst
);
  busCtl_t ctl;

  ebc_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgWaitMin(cfgWaitMin),
    .busReady(busReady), .ctl(ctl), .busy(busy), .done(done)
  );

  ebc_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqFetch(reqFetch), .reqWdata(reqWdata),
    .cfgWide(cfgWide), .cfgMux(cfgMux), .cfgBheMode(cfgBheMode), .adIn(adIn),
    .rdata(rdata), .addrOut(addrOut), .adOut(adOut), .adOe(adOe), .ale(ale),
    .rdN(rdN), .wrN(wrN), .bheN(bheN), .inst(inst)
  );
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              ale,
  input logic              rdN,
  input logic              wrN,
  input logic [1:0]        adOe,
  input logic [ADDR_W-1:0] addrOut,
  input logic              inst
);
  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  p_ale_in_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> busy);
  p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_busy_ends_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  p_idle_release_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (adOe == 2'b00));
  p_addr_held_r13: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(addrOut));
  p_inst_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(inst));
endmodule

bind ext_bus_ctrl ebc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .ale(ale), .rdN(rdN),
  .wrN(wrN), .adOe(adOe), .addrOut(addrOut), .inst(inst)
);

// File: tb/ext_bus_ctrl_tb.sv
module ext_bus_ctrl_tb;
  localparam int ADDR_W = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0, reqFetch = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [15:0] reqWdata = '0, adIn = '0;
  logic cfgWide = 1'b1, cfgMux = 1'b1, cfgBheMode = 1'b1, busReady = 1'b1;
  logic [1:0] cfgWaitMin = '0;
  logic busy, done, ale, rdN, wrN, bheN, inst;
  logic [15:0] rdata, adOut;
  logic [1:0] adOe;
  logic [ADDR_W-1:0] addrOut;

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ext_bus_ctrl #(.ADDR_W(ADDR_W), .WAIT_W(2)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWord(reqWord), .reqFetch(reqFetch),
    .reqWdata(reqWdata), .cfgWide(cfgWide), .cfgMux(cfgMux),
    .cfgBheMode(cfgBheMode), .cfgWaitMin(cfgWaitMin), .busReady(busReady),
    .adIn(adIn), .busy(busy), .done(done), .rdata(rdata), .addrOut(addrOut),
    .adOut(adOut), .adOe(adOe), .ale(ale), .rdN(rdN), .wrN(wrN),
    .bheN(bheN), .inst(inst)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected lane enables and drive value; ph 0=address 1=strobe 2=hold
  function automatic logic [17:0] expLanes(input int ph, input bit mx, input bit wd,
      input bit wr, input bit word, input logic [15:0] a, input logic [15:0] w);
    logic [1:0] oe;
    logic [15:0] v, d;
    oe = 2'b00; v = 16'h0;
    d = (wd && !word) ? {w[7:0], w[7:0]} : w;
    if (wd) begin
      if (mx) begin
        if (ph == 0) begin oe = 2'b11; v = a; end
        else if (wr) begin oe = 2'b11; v = d; end
      end else if (wr) begin oe = 2'b11; v = d; end
    end else begin
      oe[1] = 1'b1;
      v[15:8] = mx ? a[15:8] : w[15:8];
      if (mx && ph == 0) begin oe[0] = 1'b1; v[7:0] = a[7:0]; end
      else if (wr) begin oe[0] = 1'b1; v[7:0] = w[7:0]; end
    end
    return {oe, v};
  endfunction

  // Entered and left at a falling edge.
  task automatic runTxn(input bit mx, input bit wd, input bit bm, input int W,
      input int R, input bit wr, input bit word, input bit fetch,
      input logic [ADDR_W-1:0] a, input logic [15:0] w, input logic [15:0] din,
      input bit disturb);
    int S;
    string tLane, tStb;
    logic [17:0] el;
    logic [15:0] msk, expRd;
    bit a0, hs, ls, eWr, eBhe;
    S = ((W > R) ? W : R) + 1;
    a0 = a[0];
    tLane = disturb ? "R2" : (!wd ? (mx ? "R6" : "R7") : (mx ? "R5" : "R7"));
    tStb  = disturb ? "R2" : (bm ? "R8" : "R9");
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqWord = word;
    reqFetch = fetch; reqWdata = w; cfgMux = mx; cfgWide = wd;
    cfgBheMode = bm; cfgWaitMin = 2'(W); adIn = din; busReady = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k <= S + 2; k++) begin
      busReady = (k >= 1) && (k - 1 >= R);
      if (disturb && k == 1) begin
        reqValid = 1'b1; reqAddr = ~a; cfgWaitMin = 2'd3;
        cfgWide = ~wd; cfgMux = ~mx; cfgBheMode = ~bm;
      end
      if (disturb && k == S + 1) reqValid = 1'b0;
      if (k <= S + 1) begin
        int ph;
        ph = (k == 0) ? 0 : ((k <= S) ? 1 : 2);
        hs = wd && (word || a0);
        ls = !wd || word || !a0;
        if (bm) begin
          eWr = !(ph == 1 && wr);
          eBhe = !hs;
        end else begin
          eWr = !(ph == 1 && wr && ls);
          eBhe = !(ph == 1 && wr && hs);
        end
        chk(busy === 1'b1 && done === 1'b0, disturb ? "R2" : "R4",
            {busy, done}, 2'b10);
        chk(ale === (ph == 0), "R3", ale, (ph == 0));
        chk(rdN === !(ph == 1 && !wr), disturb ? "R2" : "R10", rdN, !(ph == 1 && !wr));
        chk(wrN === eWr && bheN === eBhe, tStb, {wrN, bheN}, {eWr, eBhe});
        chk(inst === (fetch && !wr), "R11", inst, (fetch && !wr));
        chk(addrOut === a, disturb ? "R2" : "R13", addrOut, a);
        el = expLanes(ph, mx, wd, wr, word, a[15:0], w);
        msk = {{8{el[17]}}, {8{el[16]}}};
        chk(adOe === el[17:16] && (adOut & msk) === (el[15:0] & msk), tLane,
            {adOe, adOut}, el);
        @(negedge clk);
      end else begin
        chk(busy === 1'b0 && done === 1'b1, disturb ? "R2" : "R3", {busy, done}, 2'b01);
        chk(adOe === 2'b00 && ale === 1'b0 && rdN === 1'b1 && wrN === 1'b1 && bheN === 1'b1,
            "R12", {adOe, ale, rdN, wrN, bheN}, 5'b00011);
        chk(addrOut === '0, "R13", addrOut, 0);
        if (!wr) begin
          if (wd && word) expRd = din;
          else if (wd && a0) expRd = {8'h00, din[15:8]};
          else expRd = {8'h00, din[7:0]};
          chk(rdata === expRd, "R10", rdata, expRd);
        end
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0 && ale === 1'b0 && inst === 1'b0 && adOe === 2'b00,
        "R1", {busy, done, ale, inst, adOe}, 0);
    chk(rdN === 1'b1 && wrN === 1'b1 && bheN === 1'b1, "R1", {rdN, wrN, bheN}, 3'b111);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && addrOut === '0, "R1", {busy, addrOut}, 0);
    // Sweep: back-to-back cycles, done overlaps the next acceptance
    for (int m = 0; m < 4; m++)
      for (int bm = 0; bm < 2; bm++)
        for (int W = 0; W < 4; W++)
          for (int R = 0; R < 4; R++)
            for (int v = 0; v < 8; v++) begin
              logic [ADDR_W-1:0] a;
              a = ADDR_W'(32'h5_1234 + idx * 773);
              a[0] = v[2];
              runTxn(m[1], m[0], bm[0], W, R, v[0], v[1], (idx % 3) == 0, a,
                     16'hC3A5 ^ 16'(idx * 41), 16'h9E37 ^ 16'(idx * 59), 1'b0);
              idx++;
            end
    // R2 mid-cycle requests and setting changes are ignored
    for (int v = 0; v < 8; v++) begin
      runTxn(v[0], v[1], v[2], 0, 1, v[0] ^ v[1], 1'b1, 1'b1,
             ADDR_W'(32'hA_55AA + v), 16'h1357 + 16'(v), 16'h2468 + 16'(v), 1'b1);
      // settings back to a defined state; let a stray request settle
      reqValid = 1'b0;
      repeat (10) @(negedge clk);
      chk(busy === 1'b0, "R2", busy, 0);
    end
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule